// File: doc/BRIEF.md
# Floating-Point Rounding Mode and Exception Flag Register Unit

This block keeps the floating-point control and status word for one hart. The word has a 3-bit dynamic rounding mode and five sticky exception flags. Software reaches this storage through three register views that share it: the whole word, the rounding mode alone, and the flags alone. Each view can be read, written, bit-set or bit-cleared. Reads return the value held before any change made in the same cycle.

For every floating-point instruction being issued, the unit turns the instruction's 3-bit rounding field into the rounding mode to use. The code 111 means "use the stored dynamic mode". If the result is a reserved code, the unit raises an illegal-instruction indication. When an instruction retires, its exception flags are ORed into the stored flags. Hardware never clears them, and setting a flag never traps.

Top module: `fp_ctrl_status`

## Requirements
- R1: After reset the rounding mode and all five flags are zero, so every view reads 0.
- R2: The whole-word view (`csr_view` = 00) reads the flags in bits 4:0 (invalid=4, divide-by-zero=3, overflow=2, underflow=1, inexact=0) and the rounding mode in bits 7:5. Bits 31:8 always read zero, whatever was written to them.
- R3: The rounding-mode view (`csr_view` = 01) reads and writes the same storage as bits 7:5 of the whole word, through its bits 2:0. The flag view (`csr_view` = 10) does the same for bits 4:0. Both views read zero-extended.
- R4: `csr_op` 01 replaces the selected field with the matching `csr_wdata` bits. 10 ORs those bits into the field. 11 clears the field bits where `csr_wdata` is 1.
- R5: `csr_rdata` shows the selected view of the stored state before any change made in that cycle. A change is visible from the next cycle on.
- R6: The effective rounding mode equals `inst_rm` when `inst_rm` is not 111. When `inst_rm` is 111, it equals the stored dynamic mode. The encodings are 000 nearest-even, 001 toward zero, 010 down, 011 up, 100 nearest with ties away from zero.
- R7: `rm_illegal` is 1 exactly when the effective rounding mode is 101, 110 or 111. This includes the case of a dynamic selection while the stored mode holds 111.
- R8: When `ret_valid` is 1, `ret_flags` are ORed into the stored flags. No flag is ever cleared except by a register write or clear.
- R9: If a register access that writes the flags and a retirement happen in the same cycle, the access is applied first and the retiring flags are ORed on top of it.
- R10: A read (`csr_op` 00), the unused view 11, or `csr_req` = 0 changes no state. The unused view reads zero.
- R11: An access through one partial view leaves the other field unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_req | input | 1 | Register access this cycle |
| csr_view | input | 2 | 00 whole word, 01 rounding mode, 10 flags, 11 unused |
| csr_op | input | 2 | 00 read, 01 write, 10 set bits, 11 clear bits |
| csr_wdata | input | 32 | Write, set or clear operand |
| csr_rdata | output | 32 | Selected view, pre-change value |
| inst_rm | input | 3 | Rounding field of the issuing instruction |
| rm_eff | output | 3 | Resolved rounding mode |
| rm_illegal | output | 1 | Resolved mode is reserved |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_flags | input | 5 | Exception flags of the retiring instruction |

## Verification
The hardest case to reach is a flag update where a register access and a retirement land in the same cycle. Here the ordering of overwrite and OR decides the result. The stimulus table pairs a flag-view write of zero with a retiring flag, and a whole-word clear of all bits with another retiring flag. It then reads the word back on the following cycle, where only the ordering of R9 gives the expected value. A second hard case is a dynamic selection while the stored mode holds the reserved 111. The only way to reach it is to set the mode bits through the rounding-mode view before issuing `inst_rm` = 111.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int RM_W  = 3;
  localparam int FLG_W = 5;

  typedef enum logic [1:0] {
    VIEW_FULL  = 2'b00,
    VIEW_RM    = 2'b01,
    VIEW_FLAGS = 2'b10,
    VIEW_NONE  = 2'b11
  } view_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } op_e;

  localparam logic [RM_W-1:0] RM_DYN        = '1;
  localparam logic [RM_W-1:0] RM_LAST_LEGAL = 3'd4;
endpackage

// File: rtl/fpc_csr_view.sv
module fpc_csr_view
  import fpc_pkg::*;
#(
  parameter int CSR_W = 32,
  parameter int RMW   = RM_W,
  parameter int FLW   = FLG_W
) (
  input  logic             req,
  input  logic [1:0]       view,
  input  logic [1:0]       op,
  input  logic [CSR_W-1:0] wdata,
  input  logic [RMW-1:0]   frm_q,
  input  logic [FLW-1:0]   flags_q,
  output logic [CSR_W-1:0] rdata,
  output logic             frm_we,
  output logic [RMW-1:0]   frm_d,
  output logic             flg_we,
  output logic [FLW-1:0]   flg_d
);
  localparam int USED_W = RMW + FLW;

  view_e             view_s;
  op_e               op_s;
  logic [USED_W-1:0] cur;
  logic [USED_W-1:0] mask;
  logic [USED_W-1:0] wd_al;
  logic [USED_W-1:0] merged;
  logic [USED_W-1:0] nxt;
  logic              wr_active;

  always_comb begin
    view_s = view_e'(view);
    op_s   = op_e'(op);
    cur    = {frm_q, flags_q};
    mask   = '0;
    wd_al  = '0;
    rdata  = '0;
    unique case (view_s)
      VIEW_FULL: begin
        mask  = '1;
        wd_al = wdata[USED_W-1:0];
        rdata = {{(CSR_W-USED_W){1'b0}}, cur};
      end
      VIEW_RM: begin
        mask  = {{RMW{1'b1}}, {FLW{1'b0}}};
        wd_al = {wdata[RMW-1:0], {FLW{1'b0}}};
        rdata = {{(CSR_W-RMW){1'b0}}, frm_q};
      end
      VIEW_FLAGS: begin
        mask  = {{RMW{1'b0}}, {FLW{1'b1}}};
        wd_al = {{RMW{1'b0}}, wdata[FLW-1:0]};
        rdata = {{(CSR_W-FLW){1'b0}}, flags_q};
      end
      default: begin
        mask  = '0;
        wd_al = '0;
        rdata = '0;
      end
    endcase

    unique case (op_s)
      OP_WRITE: merged = wd_al;
      OP_SET:   merged = cur | wd_al;
      OP_CLEAR: merged = cur & ~wd_al;
      default:  merged = cur;
    endcase

    nxt       = (cur & ~mask) | (merged & mask);
    wr_active = req && (op_s != OP_READ) && (view_s != VIEW_NONE);
    frm_we    = wr_active && (|mask[USED_W-1:FLW]);
    flg_we    = wr_active && (|mask[FLW-1:0]);
    frm_d     = nxt[USED_W-1:FLW];
    flg_d     = nxt[FLW-1:0];
  end
endmodule

// File: rtl/fpc_rm_unit.sv
module fpc_rm_unit
  import fpc_pkg::*;
#(
  parameter int RMW = RM_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frm_we,
  input  logic [RMW-1:0] frm_d,
  input  logic [RMW-1:0] inst_rm,
  output logic [RMW-1:0] frm_q,
  output logic [RMW-1:0] rm_eff,
  output logic           rm_illegal
);
  logic [RMW-1:0] frm_n;

  always_comb begin
    frm_n = frm_q;
    if (frm_we) frm_n = frm_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frm_q <= '0;
    else        frm_q <= frm_n;
  end

  always_comb begin
    rm_eff     = (inst_rm == RM_DYN) ? frm_q : inst_rm;
    rm_illegal = (rm_eff > RM_LAST_LEGAL);
  end

  AST_STATIC_LEGAL_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_rm <= RM_LAST_LEGAL) |-> !rm_illegal);  // R7
  AST_STATIC_RESERVED_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((inst_rm > RM_LAST_LEGAL) && (inst_rm != RM_DYN)) |-> rm_illegal);  // R7
  AST_FRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_we |=> $stable(frm_q));  // R10
endmodule

// File: rtl/fpc_flag_acc.sv
module fpc_flag_acc
  import fpc_pkg::*;
#(
  parameter int FLW = FLG_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flg_we,
  input  logic [FLW-1:0] flg_d,
  input  logic           ret_valid,
  input  logic [FLW-1:0] ret_flags,
  output logic [FLW-1:0] flags_q
);
  logic [FLW-1:0] base;
  logic [FLW-1:0] flags_n;

  always_comb begin
    base    = flg_we ? flg_d : flags_q;
    flags_n = base | (ret_valid ? ret_flags : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_n;
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flg_we |=> ((flags_q & $past(flags_q)) == $past(flags_q)));  // R8
  AST_RETIRE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> ((flags_q & $past(ret_flags)) == $past(ret_flags)));  // R9
  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!flg_we && !ret_valid) |=> $stable(flags_q));  // R10
endmodule

// File: rtl/fp_ctrl_status.sv
module fp_ctrl_status
  import fpc_pkg::*;
#(
  parameter int CSR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_req,
  input  logic [1:0]       csr_view,
  input  logic [1:0]       csr_op,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  input  logic [RM_W-1:0]  inst_rm,
  output logic [RM_W-1:0]  rm_eff,
  output logic             rm_illegal,
  input  logic             ret_valid,
  input  logic [FLG_W-1:0] ret_flags
);
  logic [RM_W-1:0]  frm_q;
  logic [FLG_W-1:0] flags_q;
  logic             frm_we;
  logic [RM_W-1:0]  frm_d;
  logic             flg_we;
  logic [FLG_W-1:0] flg_d;

  fpc_csr_view #(.CSR_W(CSR_W), .RMW(RM_W), .FLW(FLG_W)) u_view (
    .req     (csr_req),
    .view    (csr_view),
    .op      (csr_op),
    .wdata   (csr_wdata),
    .frm_q   (frm_q),
    .flags_q (flags_q),
    .rdata   (csr_rdata),
    .frm_we  (frm_we),
    .frm_d   (frm_d),
    .flg_we  (flg_we),
    .flg_d   (flg_d)
  );

  fpc_rm_unit #(.RMW(RM_W)) u_rm (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_we     (frm_we),
    .frm_d      (frm_d),
    .inst_rm    (inst_rm),
    .frm_q      (frm_q),
    .rm_eff     (rm_eff),
    .rm_illegal (rm_illegal)
  );

  fpc_flag_acc #(.FLW(FLG_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .flg_we    (flg_we),
    .flg_d     (flg_d),
    .ret_valid (ret_valid),
    .ret_flags (ret_flags),
    .flags_q   (flags_q)
  );

  AST_RM_VIEW_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_view == VIEW_RM && !ret_valid) |=> $stable(flags_q));  // R11
  AST_FLAG_VIEW_KEEPS_RM: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_view == VIEW_FLAGS) |=> $stable(frm_q));  // R11
  AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((!csr_req || csr_op == OP_READ || csr_view == VIEW_NONE) && !ret_valid)
      |=> ($stable(frm_q) && $stable(flags_q)));  // R10
endmodule

// File: tb/sim_fp_ctrl_status.sv
module sim_fp_ctrl_status;
  logic        clk;
  logic        rst_n;
  logic        csr_req;
  logic [1:0]  csr_view;
  logic [1:0]  csr_op;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic [2:0]  inst_rm;
  logic [2:0]  rm_eff;
  logic        rm_illegal;
  logic        ret_valid;
  logic [4:0]  ret_flags;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  fp_ctrl_status u0 (
    .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_view(csr_view),
    .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .inst_rm(inst_rm), .rm_eff(rm_eff), .rm_illegal(rm_illegal),
    .ret_valid(ret_valid), .ret_flags(ret_flags)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // fields: view, op, wdata[7:0], ret_valid, ret_flags, inst_rm, exp_rdata[7:0], exp_eff, exp_ill
  localparam int NV = 15;
  localparam logic [32:0] VEC [NV] = '{
    {2'd0, 2'd0, 8'h00, 1'b0, 5'h00, 3'd0, 8'h00, 3'd0, 1'b0}, // R1 R2 reset read
    {2'd0, 2'd1, 8'h6A, 1'b0, 5'h00, 3'd7, 8'h00, 3'd0, 1'b0}, // R4 R5 write, old read
    {2'd0, 2'd0, 8'h00, 1'b0, 5'h00, 3'd7, 8'h6A, 3'd3, 1'b0}, // R2 R6 dynamic
    {2'd1, 2'd2, 8'h04, 1'b0, 5'h00, 3'd1, 8'h03, 3'd1, 1'b0}, // R3 R4 set mode
    {2'd2, 2'd0, 8'h00, 1'b0, 5'h00, 3'd7, 8'h0A, 3'd7, 1'b1}, // R3 R7 dyn holds 111
    {2'd2, 2'd3, 8'h02, 1'b0, 5'h00, 3'd5, 8'h0A, 3'd5, 1'b1}, // R4 R7 clear flag
    {2'd0, 2'd0, 8'h00, 1'b0, 5'h00, 3'd6, 8'hE8, 3'd6, 1'b1}, // R11 R7
    {2'd1, 2'd1, 8'h02, 1'b1, 5'h01, 3'd4, 8'h07, 3'd4, 1'b0}, // R8 R11 mode write + retire
    {2'd0, 2'd0, 8'h00, 1'b1, 5'h10, 3'd7, 8'h49, 3'd2, 1'b0}, // R8 retire accumulates
    {2'd2, 2'd1, 8'h00, 1'b1, 5'h04, 3'd2, 8'h19, 3'd2, 1'b0}, // R9 write then OR
    {2'd0, 2'd2, 8'h83, 1'b0, 5'h00, 3'd3, 8'h44, 3'd3, 1'b0}, // R9 R4 set word
    {2'd3, 2'd1, 8'h00, 1'b0, 5'h00, 3'd0, 8'h00, 3'd0, 1'b0}, // R10 unused view
    {2'd0, 2'd0, 8'h00, 1'b0, 5'h00, 3'd7, 8'hC7, 3'd6, 1'b1}, // R10 unchanged
    {2'd0, 2'd3, 8'hFF, 1'b1, 5'h02, 3'd0, 8'hC7, 3'd0, 1'b0}, // R9 clear then OR
    {2'd0, 2'd0, 8'h00, 1'b0, 5'h00, 3'd7, 8'h02, 3'd0, 1'b0}  // R9 result
  };

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic req, input logic [1:0] v, input logic [1:0] o,
                       input logic [31:0] wd, input logic rv, input logic [4:0] rf,
                       input logic [2:0] rm);
    @(negedge clk);
    csr_req = req; csr_view = v; csr_op = o; csr_wdata = wd;
    ret_valid = rv; ret_flags = rf; inst_rm = rm;
    #1;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<20000", cycles);
        summary();
      end
    end
  end

  initial begin
    rst_n = 1'b0; csr_req = 1'b0; csr_view = 2'd0; csr_op = 2'd0;
    csr_wdata = '0; ret_valid = 1'b0; ret_flags = '0; inst_rm = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][32:31], VEC[i][30:29], {24'h0, VEC[i][28:21]},
            VEC[i][20], VEC[i][19:15], VEC[i][14:12]);
      check32($sformatf("vec %0d R5 rdata", i), csr_rdata, {24'h0, VEC[i][11:4]});
      check32($sformatf("vec %0d R6 rm_eff", i), {29'h0, rm_eff}, {29'h0, VEC[i][3:1]});
      check32($sformatf("vec %0d R7 rm_illegal", i), {31'h0, rm_illegal}, {31'h0, VEC[i][0]});
    end

    // R10: a write without csr_req changes nothing (state is 02)
    drive(1'b0, 2'd0, 2'd1, 32'hFFFF_FFFF, 1'b0, 5'h00, 3'd0);
    drive(1'b1, 2'd0, 2'd0, 32'h0, 1'b0, 5'h00, 3'd0);
    check32("R10 no request", csr_rdata, 32'h0000_0002);

    // R2: upper bits of a full write read back zero
    drive(1'b1, 2'd0, 2'd1, 32'hFFFF_FFFF, 1'b0, 5'h00, 3'd0);
    drive(1'b1, 2'd0, 2'd0, 32'h0, 1'b0, 5'h00, 3'd0);
    check32("R2 reserved zero", csr_rdata, 32'h0000_00FF);
    drive(1'b1, 2'd1, 2'd0, 32'h0, 1'b0, 5'h00, 3'd0);
    check32("R3 mode view", csr_rdata, 32'h0000_0007);
    drive(1'b1, 2'd2, 2'd0, 32'h0, 1'b0, 5'h00, 3'd0);
    check32("R3 flag view", csr_rdata, 32'h0000_001F);

    // R6 R7: sweep every instruction field with stored mode 111, then 010
    for (int m = 0; m < 8; m++) begin
      drive(1'b0, 2'd0, 2'd0, 32'h0, 1'b0, 5'h00, 3'(m));
      check32("R6 sweep eff", {29'h0, rm_eff}, (m == 7) ? 32'd7 : 32'(m));
      check32("R7 sweep illegal", {31'h0, rm_illegal}, (m >= 5) ? 32'd1 : 32'd0);
    end
    drive(1'b1, 2'd1, 2'd1, 32'h2, 1'b0, 5'h00, 3'd0);
    for (int m = 0; m < 8; m++) begin
      drive(1'b0, 2'd0, 2'd0, 32'h0, 1'b0, 5'h00, 3'(m));
      check32("R6 sweep eff frm2", {29'h0, rm_eff}, (m == 7) ? 32'd2 : 32'(m));
      check32("R7 sweep illegal frm2", {31'h0, rm_illegal},
              (m == 5 || m == 6) ? 32'd1 : 32'd0);
    end

    // R1: asynchronous reset clears a non-zero state
    @(negedge clk);
    csr_req = 1'b0; csr_view = 2'd0; csr_op = 2'd0;
    rst_n = 1'b0;
    #1;
    check32("R1 reset clears", csr_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 2'd0, 2'd0, 32'h0, 1'b0, 5'h00, 3'd7);
    check32("R1 after release", csr_rdata, 32'h0);
    check32("R1 dyn after reset", {29'h0, rm_eff}, 32'h0);

    summary();
  end
endmodule